// File: doc/BRIEF.md
# Symmetric Six-Tap FIR Filter with Pre-Addition

This block is a linear-phase FIR filter with six taps whose coefficients mirror each other. Two taps share each coefficient. The filter first adds the two delayed samples that share a coefficient, then multiplies that sum once. Six products therefore cost only three multipliers. The three weighted sums flow through a transposed accumulation chain that holds one register per coefficient. The last register of that chain drives the output port directly.

A producer presents one signed sample per cycle together with a valid strobe. The three signed coefficients are held constant while the filter runs. Every register in the block advances only on cycles that carry a valid sample. Idle cycles therefore neither change the result nor shift the history. One cycle after each accepted sample, the block raises its output strobe and presents the filtered value. That value lags the accepted sample by a fixed number of samples.

Top module: `fir_sym6`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_sample` becomes 0 and `out_valid` becomes 0 after that edge, and all sample history is cleared.
- R2: `out_valid` is high in the cycle after each edge at which `in_valid` was high, and low after each edge at which `in_valid` was low.
- R3: Coefficient t (t = 0, 1, 2) is taken from `coef[18t+17:18t]` as an 18-bit signed value. The impulse response is h = [c0, c1, c2, c2, c1, c0].
- R4: Count accepted samples x(0), x(1), ... from reset, with x(j) = 0 for j < 0. After x(n) is accepted, `out_sample` equals the 48-bit signed sum over i = 0..5 of h[i]·x(n−5−i). This is a latency of five samples.
- R5: A single 1 followed by zeros produces the outputs c0, c1, c2, c2, c1, c0 on accepted samples 5 through 10. All other outputs are 0.
- R6: A constant input A gives the settled output 2·(c0+c1+c2)·A from the tenth accepted sample onward.
- R7: Cycles with `in_valid` low leave `out_sample` unchanged. Inserting such idle cycles between samples does not change any later result.
- R8: The pair sums and the products are exact across the full 18-bit signed range of samples and coefficients, including −131072 on every input.
- R9: A reset asserted in the middle of a stream discards all earlier samples. Outputs after the reset follow R4 with the sample count restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; the pipeline advances only when high |
| in_sample | input | 18 | Signed input sample |
| coef | input | 54 | Three signed 18-bit coefficients, c0 in the low bits |
| out_valid | output | 1 | High the cycle after an accepted sample |
| out_sample | output | 48 | Signed filtered sample |

## Verification
The bench builds the block with its default parameters: 18-bit samples and coefficients, a 25-bit pre-add, a 48-bit accumulation and three coefficient pairs. This size makes it practical to compare every output with a direct convolution over an eleven-sample history. With the default widths, the full-scale negative corner is reachable, which tests that the pre-add carry and the product sign are exact. Because idle cycles are mixed in between samples, the bench also shows that the delay line and the accumulation chain stay aligned whatever the gaps between samples.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

    localparam int FIR_SAMPLE_W = 18;
    localparam int FIR_COEF_W   = 18;
    localparam int FIR_PRE_W    = 25;
    localparam int FIR_ACC_W    = 48;
    localparam int FIR_PAIRS    = 3;

    // Delay-line tap feeding the stepping operand of pair t.
    function automatic int near_tap(input int t);
        return 2 * t;
    endfunction

    // Delay-line tap shared by all pairs as the second operand.
    function automatic int far_tap(input int pairs);
        return 2 * pairs - 1;
    endfunction

endpackage

// File: rtl/fir_sym_delay.sv
module fir_sym_delay #(
    parameter int W     = 18,
    parameter int DEPTH = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [W-1:0]         din,
    output logic [DEPTH*W-1:0]   taps
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] line;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.line[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.line[i] = st_q.line[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps = st_q.line;

    assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.line));

    assert_line_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> st_q.line[0] == $past(din));

endmodule

// File: rtl/fir_sym_tap.sv
module fir_sym_tap #(
    parameter int SAMPLE_W = 18,
    parameter int COEF_W   = 18,
    parameter int PRE_W    = 25,
    parameter int ACC_W    = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic signed [SAMPLE_W-1:0] samp_a,
    input  logic signed [SAMPLE_W-1:0] samp_b,
    input  logic signed [COEF_W-1:0]   coef,
    input  logic signed [ACC_W-1:0]    acc_in,
    output logic signed [ACC_W-1:0]    acc_out
);

    localparam int MUL_W = PRE_W + COEF_W;

    typedef struct packed {
        logic signed [PRE_W-1:0] pre;
        logic signed [MUL_W-1:0] prod;
        logic signed [ACC_W-1:0] acc;
    } tap_state_t;

    tap_state_t st_d, st_q;

    logic signed [PRE_W-1:0] a_ext, b_ext;
    logic signed [MUL_W-1:0] pre_wide, coef_wide;

    always_comb begin
        a_ext     = PRE_W'(samp_a);
        b_ext     = PRE_W'(samp_b);
        pre_wide  = MUL_W'(st_q.pre);
        coef_wide = MUL_W'(coef);
        st_d      = st_q;
        if (adv) begin
            st_d.pre  = a_ext + b_ext;
            st_d.prod = pre_wide * coef_wide;
            st_d.acc  = ACC_W'(st_q.prod) + acc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out = st_q.acc;

    assert_tap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.acc) && $stable(st_q.prod));

endmodule

// File: rtl/fir_sym6.sv
module fir_sym6
    import fir_sym_pkg::*;
#(
    parameter int SAMPLE_W  = FIR_SAMPLE_W,
    parameter int COEF_W    = FIR_COEF_W,
    parameter int PRE_W     = FIR_PRE_W,
    parameter int ACC_W     = FIR_ACC_W,
    parameter int NUM_PAIRS = FIR_PAIRS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [SAMPLE_W-1:0]           in_sample,
    input  logic [NUM_PAIRS*COEF_W-1:0]   coef,
    output logic                          out_valid,
    output logic [ACC_W-1:0]              out_sample
);

    localparam int DEPTH = 2 * NUM_PAIRS;
    localparam int FAR   = far_tap(NUM_PAIRS);

    typedef struct packed {
        logic vld;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [DEPTH*SAMPLE_W-1:0]     taps;
    logic [NUM_PAIRS:0][ACC_W-1:0] chain;

    fir_sym_delay #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_valid),
        .din  (in_sample),
        .taps (taps)
    );

    // First adder of the chain starts from zero.
    assign chain[0] = '0;

    for (genvar t = 0; t < NUM_PAIRS; t++) begin : g_pair
        localparam int NEAR = near_tap(t);
        fir_sym_tap #(
            .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
            .PRE_W(PRE_W), .ACC_W(ACC_W)
        ) u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (in_valid),
            .samp_a (taps[NEAR*SAMPLE_W +: SAMPLE_W]),
            .samp_b (taps[FAR*SAMPLE_W +: SAMPLE_W]),
            .coef   (coef[t*COEF_W +: COEF_W]),
            .acc_in (chain[t]),
            .acc_out(chain[t+1])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_sample = chain[NUM_PAIRS];

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_sample == '0) && !out_valid);

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

endmodule

// File: tb/fir_sym6_test.sv
module fir_sym6_test;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 18;
    localparam int CW = 18;
    localparam int AW = 48;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              in_valid = 0;
    logic [SW-1:0]     in_sample = '0;
    logic [3*CW-1:0]   coef = '0;
    logic              out_valid;
    logic [AW-1:0]     out_sample;

    int total = 0;
    int fails = 0;
    longint hist [0:10];
    longint kc [0:2];

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_sym6 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_sample(in_sample), .coef(coef),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic longint out_val();
        return longint'($signed(out_sample));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_coefs(input longint c0, input longint c1, input longint c2);
        kc[0] = c0; kc[1] = c1; kc[2] = c2;
        coef = {CW'(c2), CW'(c1), CW'(c0)};
    endtask

    function automatic longint model_out();
        longint h [0:5];
        longint s = 0;
        h[0] = kc[0]; h[1] = kc[1]; h[2] = kc[2];
        h[3] = kc[2]; h[4] = kc[1]; h[5] = kc[0];
        for (int i = 0; i < 6; i++) s += h[i] * hist[5+i];
        return s;
    endfunction

    // R1: reset clears outputs and the model history
    task automatic do_reset(input bit check_it);
        rst_n = 0;
        in_valid = 0;
        for (int i = 0; i < 11; i++) hist[i] = 0;
        @(negedge clk);
        @(negedge clk);
        if (check_it) begin
            check("R1 out_sample", out_val(), 0);
            check("R1 out_valid", longint'(out_valid), 0);
        end
        rst_n = 1;
    endtask

    // One accepted sample, checked against the convolution (R2, R4)
    task automatic send(input longint x, input string req);
        in_sample = SW'(x);
        in_valid  = 1;
        @(negedge clk);
        in_valid  = 0;
        for (int i = 10; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        check("R2 out_valid", longint'(out_valid), 1);
        check(req, out_val(), model_out());
    endtask

    // Idle cycles: nothing moves (R7)
    task automatic idle(input int n);
        longint prev;
        for (int i = 0; i < n; i++) begin
            prev = out_val();
            in_sample = SW'(i * 977 - 3000);
            @(negedge clk);
            check("R7 hold", out_val(), prev);
            check("R2 idle valid", longint'(out_valid), 0);
        end
    endtask

    task automatic test_reset();
        set_coefs(3, -7, 11);
        do_reset(1);
    endtask

    task automatic test_impulse();
        set_coefs(3, -7, 11);
        do_reset(0);
        send(1, "R4 impulse");
        for (int i = 1; i <= 11; i++) begin
            send(0, "R4 impulse");
            if (i == 5)  check("R5 tap0", out_val(), 3);
            if (i == 7)  check("R5 tap2", out_val(), 11);
            if (i == 8)  check("R5 tap3 R3", out_val(), 11);
            if (i == 10) check("R5 tap5", out_val(), 3);
            if (i == 11) check("R5 tail", out_val(), 0);
        end
    endtask

    task automatic test_step();
        set_coefs(5, 2, -4);
        do_reset(0);
        for (int i = 0; i < 14; i++) send(1000, "R4 step");
        check("R6 settled", out_val(), 2 * (5 + 2 - 4) * 1000);
    endtask

    task automatic test_gaps();
        set_coefs(-9, 13, 21);
        do_reset(0);
        for (int i = 0; i < 16; i++) begin
            send(longint'((i * 7919) % 2001) - 1000, "R7 gapped stream");
            idle((i % 3) + 1);
        end
    endtask

    task automatic test_extreme();
        set_coefs(-131072, -131072, -131072);
        do_reset(0);
        for (int i = 0; i < 12; i++) send(-131072, "R8 full scale");
        check("R8 corner", out_val(), 6 * 131072 * 131072);
        for (int i = 0; i < 12; i++)
            send((i % 2 == 0) ? 131071 : -131072, "R8 alternating");
    endtask

    task automatic test_midreset();
        set_coefs(4, -6, 8);
        do_reset(0);
        for (int i = 0; i < 7; i++) send(500 + i, "R4 pre-reset");
        do_reset(1);
        send(2, "R9 restart");
        for (int i = 0; i < 10; i++) send(0, "R9 restart");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_impulse();
        test_step();
        test_gaps();
        test_extreme();
        test_midreset();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule